// File: doc/BRIEF.md
# Oscillator Stop and Restart Monitor

This block watches a main clock from a free-running internal reference clock. It reports two events: the main clock going silent (a stop) and the main clock coming back after a stop (a restart). Each main-clock rising edge flips a toggle flop in the main domain. The toggle crosses into the reference domain through a synchronizer, and an edge detector there turns each change into a one-cycle activity pulse. Two counters in the reference domain turn those pulses into the events. A stop is declared when no activity pulse arrives for `timeout_lim` reference cycles. A restart is declared after `restart_lim` activity pulses with no stop declared in between. The usual settings are 8 and 4.

A detection-enable input gates the whole function. A mode input selects the action taken for an event. In reset mode, a stop raises a system reset request that stays high until the external hardware reset. In interrupt mode, a stop or a restart produces a one-cycle interrupt pulse. A stop in interrupt mode also moves the CPU clock selection to the internal oscillator, but only when the main clock, not the PLL, is driving the CPU. Two status flags are kept: a sticky "event seen" flag and a "main clock stopped" flag. Software can clear the event flag and rewrite the clock selection. The block only produces the select bit; the glitch-free clock multiplexer sits elsewhere. Reliable detection assumes a main clock of at least 2 MHz, and a reference clock fast enough to see every toggle of the activity signal.

Top module: `osc_watch`

## Requirements
- R1: While `rst_n` is low and right after it is released, `irq`, `sys_rst_req`, `evt_flag`, `stopped_flag` and `osc_sel` are all 0.
- R2: While `det_en` is 0, stopping or restarting the main clock produces no `irq` pulse, no `sys_rst_req`, and no change of `evt_flag`, `stopped_flag` or `osc_sel`.
- R3: With `det_en`=1 and `act_irq`=1, a stop produces exactly one `irq` pulse, one reference cycle wide, and sets both `evt_flag` and `stopped_flag` to 1.
- R4: In interrupt mode with `pll_src`=0 (main clock drives the CPU), a stop sets `osc_sel` to 1, meaning the internal oscillator is selected.
- R5: In interrupt mode with `pll_src`=1, a stop leaves `osc_sel` unchanged but still pulses `irq` once and sets both flags.
- R6: In interrupt mode, a restart while `stopped_flag` is 1 pulses `irq` once, keeps `evt_flag` at 1, clears `stopped_flag` to 0, and leaves `osc_sel` unchanged.
- R7: With `det_en`=1 and `act_irq`=0, a stop sets `sys_rst_req` and both status flags, with no `irq` pulse and `osc_sel` unchanged. A later restart changes nothing, and `sys_rst_req` stays 1 until `rst_n` goes low.
- R8: `evt_flag` is sticky: it stays 1 until a one-cycle `flag_clr` pulse clears it to 0. If an event arrives in the same cycle as `flag_clr`, the event wins.
- R9: A main clock that keeps running, with `stopped_flag` at 0, never produces an `irq` pulse.
- R10: A stop is declared only after `timeout_lim` reference cycles without main-clock activity. A shorter gap, followed by resumed activity, produces no event.
- R11: A cycle with `sel_wr`=1 loads `sel_wdata` into `osc_sel`, unless a stop-driven switch to the internal oscillator happens in the same cycle, which takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running internal reference clock; all state except the toggle runs on it |
| rst_n | input | 1 | Hardware reset, active low, asserted asynchronously, released synchronously |
| main_clk | input | 1 | Main clock under observation |
| det_en | input | 1 | Enables stop/restart detection actions |
| act_irq | input | 1 | Action select: 0 = system reset on stop, 1 = interrupt on stop or restart |
| pll_src | input | 1 | 1 when the PLL, not the main clock, is the CPU clock source |
| timeout_lim | input | CNT_W | Reference cycles without activity that declare a stop |
| restart_lim | input | CNT_W | Activity pulses after a stop that declare a restart |
| flag_clr | input | 1 | Software write of 0 to the event flag |
| sel_wr | input | 1 | Software write strobe for the clock-select bit |
| sel_wdata | input | 1 | Value written to the clock-select bit |
| irq | output | 1 | One-cycle interrupt request per event in interrupt mode |
| sys_rst_req | output | 1 | Sticky system reset request in reset mode |
| evt_flag | output | 1 | Sticky "event seen" status |
| stopped_flag | output | 1 | "Main clock currently stopped" status |
| osc_sel | output | 1 | CPU clock select: 1 = internal oscillator, 0 = main clock path |

## Verification
The hardest state to reach from the ports is a restart seen after a real stop, with the flags and the clock selection carried over from that stop. The bench drives the main clock from a gated generator whose period is not a multiple of the reference period. Silencing the generator for far longer than the timeout produces the stop. Turning it back on produces a restart, and the bench checks that `osc_sel` stays as the stop left it. The near-miss case is built the same way: a gap shorter than a raised timeout, which must produce no event. A monitor counts `irq` pulses and their widths, so each scenario can state exactly how many interrupts it expects.

// File: rtl/osc_watch_pkg.sv
package osc_watch_pkg;

  typedef enum logic {
    ACT_RESET = 1'b0,
    ACT_IRQ   = 1'b1
  } act_mode_e;

  typedef struct packed {
    logic stop_hit;
    logic restart_hit;
  } sense_t;

endpackage

// File: rtl/osc_rst_sync.sv
module osc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/osc_toggle_src.sv
module osc_toggle_src (
  input  logic main_clk,
  input  logic arst_n,
  output logic tog
);

  logic tog_q;
  logic tog_d;

  always_comb begin
    tog_d = ~tog_q;
  end

  always_ff @(posedge main_clk or negedge arst_n) begin
    if (!arst_n) begin
      tog_q <= 1'b0;
    end else begin
      tog_q <= tog_d;
    end
  end

  assign tog = tog_q;

endmodule

// File: rtl/osc_edge_sense.sv
module osc_edge_sense #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_async,
  output logic act_pulse
);

  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], tog_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign act_pulse = sync_q[DEPTH-1] ^ sync_q[DEPTH-2];

endmodule

// File: rtl/osc_activity_cnt.sv
module osc_activity_cnt
  import osc_watch_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_pulse,
  input  logic [CNT_W-1:0] timeout_lim,
  input  logic [CNT_W-1:0] restart_lim,
  output sense_t           sense
);

  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] idle_q, idle_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic [EXT_W-1:0] idle_inc, run_inc;
  logic             idle_sat, run_sat;
  logic             stop_hit, restart_hit;

  always_comb begin
    idle_inc    = {1'b0, idle_q} + EXT_W'(1);
    run_inc     = {1'b0, run_q} + EXT_W'(1);
    idle_sat    = (idle_q >= timeout_lim);
    run_sat     = (run_q >= restart_lim);
    stop_hit    = !act_pulse && !idle_sat && (idle_inc == {1'b0, timeout_lim});
    restart_hit = act_pulse && !run_sat && (run_inc == {1'b0, restart_lim});

    if (act_pulse) begin
      idle_d = '0;
    end else if (idle_sat) begin
      idle_d = idle_q;
    end else begin
      idle_d = idle_inc[CNT_W-1:0];
    end

    if (stop_hit) begin
      run_d = '0;
    end else if (act_pulse && !run_sat) begin
      run_d = run_inc[CNT_W-1:0];
    end else begin
      run_d = run_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      run_q  <= '0;
    end else begin
      idle_q <= idle_d;
      run_q  <= run_d;
    end
  end

  assign sense.stop_hit    = stop_hit;
  assign sense.restart_hit = restart_hit;

endmodule

// File: rtl/osc_event_ctrl.sv
module osc_event_ctrl
  import osc_watch_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   det_en,
  input  logic   act_irq,
  input  logic   pll_src,
  input  logic   flag_clr,
  input  logic   sel_wr,
  input  logic   sel_wdata,
  input  sense_t sense,
  output logic   irq,
  output logic   sys_rst_req,
  output logic   evt_flag,
  output logic   stopped_flag,
  output logic   osc_sel
);

  act_mode_e mode;
  logic      stop_evt, restart_evt, any_evt, auto_switch;
  logic      irq_q, irq_d;
  logic      rreq_q, rreq_d;
  logic      evt_q, evt_d;
  logic      stp_q, stp_d;
  logic      sel_q, sel_d;

  always_comb begin
    mode        = act_mode_e'(act_irq);
    stop_evt    = det_en && sense.stop_hit;
    restart_evt = det_en && sense.restart_hit && stp_q && (mode == ACT_IRQ);
    any_evt     = stop_evt || restart_evt;
    auto_switch = stop_evt && (mode == ACT_IRQ) && !pll_src;

    irq_d  = any_evt && (mode == ACT_IRQ);
    rreq_d = rreq_q || (stop_evt && (mode == ACT_RESET));

    if (any_evt) begin
      evt_d = 1'b1;
    end else if (flag_clr) begin
      evt_d = 1'b0;
    end else begin
      evt_d = evt_q;
    end

    if (stop_evt) begin
      stp_d = 1'b1;
    end else if (restart_evt) begin
      stp_d = 1'b0;
    end else begin
      stp_d = stp_q;
    end

    if (auto_switch) begin
      sel_d = 1'b1;
    end else if (sel_wr) begin
      sel_d = sel_wdata;
    end else begin
      sel_d = sel_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      rreq_q <= 1'b0;
      evt_q  <= 1'b0;
      stp_q  <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      rreq_q <= rreq_d;
      evt_q  <= evt_d;
      stp_q  <= stp_d;
      sel_q  <= sel_d;
    end
  end

  assign irq          = irq_q;
  assign sys_rst_req  = rreq_q;
  assign evt_flag     = evt_q;
  assign stopped_flag = stp_q;
  assign osc_sel      = sel_q;

endmodule

// File: rtl/osc_watch.sv
module osc_watch
  import osc_watch_pkg::*;
#(
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             main_clk,
  input  logic             det_en,
  input  logic             act_irq,
  input  logic             pll_src,
  input  logic [CNT_W-1:0] timeout_lim,
  input  logic [CNT_W-1:0] restart_lim,
  input  logic             flag_clr,
  input  logic             sel_wr,
  input  logic             sel_wdata,
  output logic             irq,
  output logic             sys_rst_req,
  output logic             evt_flag,
  output logic             stopped_flag,
  output logic             osc_sel
);

  logic   ref_rst_n;
  logic   tog;
  logic   act_pulse;
  sense_t sense;

  osc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (ref_clk),
    .arst_n  (rst_n),
    .rst_n_o (ref_rst_n)
  );

  osc_toggle_src u_toggle (
    .main_clk (main_clk),
    .arst_n   (rst_n),
    .tog      (tog)
  );

  osc_edge_sense #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (ref_clk),
    .rst_n     (ref_rst_n),
    .tog_async (tog),
    .act_pulse (act_pulse)
  );

  osc_activity_cnt #(.CNT_W(CNT_W)) u_count (
    .clk         (ref_clk),
    .rst_n       (ref_rst_n),
    .act_pulse   (act_pulse),
    .timeout_lim (timeout_lim),
    .restart_lim (restart_lim),
    .sense       (sense)
  );

  osc_event_ctrl u_ctrl (
    .clk          (ref_clk),
    .rst_n        (ref_rst_n),
    .det_en       (det_en),
    .act_irq      (act_irq),
    .pll_src      (pll_src),
    .flag_clr     (flag_clr),
    .sel_wr       (sel_wr),
    .sel_wdata    (sel_wdata),
    .sense        (sense),
    .irq          (irq),
    .sys_rst_req  (sys_rst_req),
    .evt_flag     (evt_flag),
    .stopped_flag (stopped_flag),
    .osc_sel      (osc_sel)
  );

endmodule

// File: rtl/osc_watch_chk.sv
module osc_watch_chk (
  input logic ref_clk,
  input logic rst_n,
  input logic det_en,
  input logic act_irq,
  input logic pll_src,
  input logic flag_clr,
  input logic sel_wr,
  input logic irq,
  input logic sys_rst_req,
  input logic evt_flag,
  input logic stopped_flag,
  input logic osc_sel
);

  // R2
  disabled_quiet_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!det_en && !flag_clr && !sel_wr) |=>
      (!irq && $stable(sys_rst_req) && $stable(evt_flag) && $stable(stopped_flag) && $stable(osc_sel)));

  // R3
  irq_single_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    irq |=> !irq);

  // R3
  irq_flags_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    irq |-> evt_flag);

  // R7
  irq_mode_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    irq |-> $past(act_irq));

  // R7
  rst_req_sticky_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sys_rst_req |=> sys_rst_req);

  // R7
  rst_req_cause_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> ($past(det_en) && !$past(act_irq)));

  // R5
  sel_switch_cause_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(osc_sel) |-> ($past(sel_wr) || ($past(act_irq) && !$past(pll_src))));

endmodule

bind osc_watch osc_watch_chk u_osc_watch_chk (
  .ref_clk      (ref_clk),
  .rst_n        (rst_n),
  .det_en       (det_en),
  .act_irq      (act_irq),
  .pll_src      (pll_src),
  .flag_clr     (flag_clr),
  .sel_wr       (sel_wr),
  .irq          (irq),
  .sys_rst_req  (sys_rst_req),
  .evt_flag     (evt_flag),
  .stopped_flag (stopped_flag),
  .osc_sel      (osc_sel)
);

// File: tb/osc_watch_bench.sv
`timescale 1ns/1ps
module osc_watch_bench;

  localparam int CNT_W = 6;

  logic             ref_clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             main_clk = 1'b0;
  logic             main_run = 1'b1;
  logic             det_en = 1'b0;
  logic             act_irq = 1'b1;
  logic             pll_src = 1'b0;
  logic [CNT_W-1:0] timeout_lim = 6'd8;
  logic [CNT_W-1:0] restart_lim = 6'd4;
  logic             flag_clr = 1'b0;
  logic             sel_wr = 1'b0;
  logic             sel_wdata = 1'b0;
  logic             irq, sys_rst_req, evt_flag, stopped_flag, osc_sel;

  int errors = 0;
  int checks = 0;
  int irq_cnt = 0;
  int irq_run = 0;
  int irq_wmax = 0;
  bit done = 1'b0;

  osc_watch #(.CNT_W(CNT_W)) u_osc_watch (
    .ref_clk      (ref_clk),
    .rst_n        (rst_n),
    .main_clk     (main_clk),
    .det_en       (det_en),
    .act_irq      (act_irq),
    .pll_src      (pll_src),
    .timeout_lim  (timeout_lim),
    .restart_lim  (restart_lim),
    .flag_clr     (flag_clr),
    .sel_wr       (sel_wr),
    .sel_wdata    (sel_wdata),
    .irq          (irq),
    .sys_rst_req  (sys_rst_req),
    .evt_flag     (evt_flag),
    .stopped_flag (stopped_flag),
    .osc_sel      (osc_sel)
  );

  // 50 MHz reference clock
  initial forever #10 ref_clk = ~ref_clk;

  // gated main clock, 62 ns period, unrelated to the reference
  initial forever begin
    #31;
    if (main_run) main_clk = ~main_clk;
  end

  always @(negedge ref_clk) begin
    if (irq) begin
      irq_cnt++;
      irq_run++;
      if (irq_run > irq_wmax) irq_wmax = irq_run;
    end else begin
      irq_run = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic clear_irq_stats();
    irq_cnt  = 0;
    irq_wmax = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wait_ref(4);
    check(!irq && !sys_rst_req && !evt_flag && !stopped_flag && !osc_sel, "R1 outputs in reset",
          {irq, sys_rst_req, evt_flag, stopped_flag, osc_sel}, 0);
    rst_n = 1'b1;
    wait_ref(6);
    check(!irq && !sys_rst_req && !evt_flag && !stopped_flag && !osc_sel, "R1 outputs after release",
          {irq, sys_rst_req, evt_flag, stopped_flag, osc_sel}, 0);
  endtask

  task automatic t_disabled();
    det_en = 1'b0; act_irq = 1'b1; pll_src = 1'b0;
    clear_irq_stats();
    main_run = 1'b0;
    wait_ref(40);
    check(irq_cnt == 0, "R2 no irq on stop while disabled", irq_cnt, 0);
    check(!evt_flag && !stopped_flag && !osc_sel && !sys_rst_req, "R2 state unchanged on stop",
          {sys_rst_req, evt_flag, stopped_flag, osc_sel}, 0);
    main_run = 1'b1;
    wait_ref(50);
    check(irq_cnt == 0 && !evt_flag && !stopped_flag && !osc_sel, "R2 restart while disabled",
          irq_cnt, 0);
  endtask

  task automatic t_running();
    det_en = 1'b1; act_irq = 1'b1;
    clear_irq_stats();
    wait_ref(120);
    check(irq_cnt == 0, "R9 running clock gives no irq", irq_cnt, 0);
    check(!evt_flag && !stopped_flag, "R9 flags stay clear", {evt_flag, stopped_flag}, 0);
  endtask

  task automatic t_short_gap();
    timeout_lim = 6'd20;
    clear_irq_stats();
    main_run = 1'b0;
    wait_ref(10);
    main_run = 1'b1;
    wait_ref(50);
    check(irq_cnt == 0 && !stopped_flag && !evt_flag, "R10 short gap ignored", irq_cnt, 0);
    timeout_lim = 6'd8;
    wait_ref(10);
  endtask

  task automatic t_stop_main();
    pll_src = 1'b0;
    clear_irq_stats();
    main_run = 1'b0;
    wait_ref(40);
    check(irq_cnt == 1, "R3 one irq on stop", irq_cnt, 1);
    check(irq_wmax == 1, "R3 irq one cycle wide", irq_wmax, 1);
    check(evt_flag && stopped_flag, "R3 flags set on stop", {evt_flag, stopped_flag}, 3);
    check(osc_sel == 1'b1, "R4 switch to internal oscillator", osc_sel, 1);
  endtask

  task automatic t_restart();
    clear_irq_stats();
    main_run = 1'b1;
    wait_ref(50);
    check(irq_cnt == 1, "R6 one irq on restart", irq_cnt, 1);
    check(evt_flag == 1'b1, "R6 event flag set", evt_flag, 1);
    check(stopped_flag == 1'b0, "R6 stopped flag cleared", stopped_flag, 0);
    check(osc_sel == 1'b1, "R6 select unchanged", osc_sel, 1);
  endtask

  task automatic t_sw_access();
    wait_ref(20);
    check(evt_flag == 1'b1, "R8 event flag sticky", evt_flag, 1);
    flag_clr = 1'b1;
    wait_ref(1);
    flag_clr = 1'b0;
    wait_ref(1);
    check(evt_flag == 1'b0, "R8 flag cleared by write", evt_flag, 0);
    sel_wr = 1'b1; sel_wdata = 1'b0;
    wait_ref(1);
    sel_wr = 1'b0;
    wait_ref(1);
    check(osc_sel == 1'b0, "R11 software select write", osc_sel, 0);
  endtask

  task automatic t_stop_pll();
    pll_src = 1'b1;
    clear_irq_stats();
    main_run = 1'b0;
    wait_ref(40);
    check(irq_cnt == 1, "R5 one irq on stop with PLL source", irq_cnt, 1);
    check(evt_flag && stopped_flag, "R5 flags set", {evt_flag, stopped_flag}, 3);
    check(osc_sel == 1'b0, "R5 select unchanged", osc_sel, 0);
    main_run = 1'b1;
    wait_ref(50);
    check(irq_cnt == 2 && !stopped_flag && osc_sel == 1'b0, "R6 restart after PLL stop", irq_cnt, 2);
    flag_clr = 1'b1;
    wait_ref(1);
    flag_clr = 1'b0;
    pll_src = 1'b0;
    wait_ref(2);
  endtask

  task automatic t_reset_mode();
    act_irq = 1'b0;
    clear_irq_stats();
    main_run = 1'b0;
    wait_ref(40);
    check(sys_rst_req == 1'b1, "R7 reset request on stop", sys_rst_req, 1);
    check(irq_cnt == 0, "R7 no irq in reset mode", irq_cnt, 0);
    check(evt_flag && stopped_flag && !osc_sel, "R7 flags set, select kept",
          {evt_flag, stopped_flag, osc_sel}, 6);
    main_run = 1'b1;
    wait_ref(50);
    check(sys_rst_req && stopped_flag && irq_cnt == 0, "R7 restart changes nothing",
          {sys_rst_req, stopped_flag}, 3);
    rst_n = 1'b0;
    wait_ref(2);
    check(sys_rst_req == 1'b0, "R7 hardware reset clears request", sys_rst_req, 0);
    rst_n = 1'b1;
    wait_ref(6);
    check(!sys_rst_req && !stopped_flag && !evt_flag, "R7 clean after reset",
          {sys_rst_req, stopped_flag, evt_flag}, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_disabled();
    t_running();
    t_short_gap();
    t_stop_main();
    t_restart();
    t_sw_access();
    t_stop_pll();
    t_reset_mode();
    finish_run();
  end

endmodule